// File: doc/BRIEF.md
# Fractional Backlight PWM Generator

This block produces the pulse-width-modulated level that drives a display backlight. A free-running counter advances on a prescaled tick. The period length comes from a period value masked to a programmable number of low bits. The output is high for the first part of each period. How long it stays high is set by a 16-bit left-justified duty word. In fractional mode, the duty bits below the period resolution are not thrown away. A first-order accumulator collects them and adds one extra high tick to a period each time it overflows. Averaged over many periods, the duty therefore keeps its full 16-bit precision.

Software reaches the block through a simple write port and a combinational read port. Control and period values land in shadow registers. Shadow values reach the active copies only at a period boundary, and only while no lock is in effect. A group lock bit, or a chip-wide master lock input that a companion bit can tell the block to ignore, holds all shadow values back. Releasing the lock, or writing while unlocked, raises an update-pending status bit. That bit clears on the very edge where the new values take effect, so a group of writes is always applied together.

Top module: `bl_pwm_gen`

## Requirements
- R1: After reset, the output is low and all three registers read zero: control at address 0, period at address 1, lock/status at address 2. Address 3 always reads zero.
- R2: The period bit-count field sits at period-register bits [19:16], and a value of 0 means 16 bits. The period value is bits [15:0], masked to that many low bits. The counter advances only on a cycle with `tick` high and wraps after that many ticks.
- R3: With fractional mode off, the output is high for the first N ticks of each period. N is the top bit-count bits of the duty word in control bits [15:0]; the lower duty bits have no effect.
- R4: With fractional mode on (control bit 17), the low (16 minus bit-count) duty bits are added into an accumulator at every period wrap. A wrap whose sum overflows makes the following period one tick longer high.
- R5: Control bit 16 enables the output; when it is clear the output stays low. A masked period of 0 also keeps the output low.
- R6: While a lock is in effect, written control and period values leave the output unchanged, and the pending bit (lock register bit 8) is not raised by those writes.
- R7: Releasing the lock bit (lock register bit 0) sets the pending bit. The shadow values are then copied at the first period wrap, and pending clears on that same edge.
- R8: A high `master_lock` input acts as a lock, unless the ignore-master bit (lock register bit 1) is set. Setting that bit while the master lock is high releases the hold.
- R9: A write to the control or period register while unlocked sets the pending bit, and the value takes effect at the next period wrap.
- R10: The control and period registers read back the last written shadow values. The lock register reads back its lock bit, its ignore bit and the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| master_lock | input | 1 | Chip-wide register lock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| pwm_out | output | 1 | Backlight PWM level |

## Verification
The duty path is tried with a masked non-zero bit-count, with the bit-count of 0 that stands for 16, with a tick only every third cycle, and with the same duty word in integer and in fractional mode. Counting high cycles over whole-pattern windows then tells period masking, justification and dithering apart. The update path is tried with lock-bit holds, master-lock holds with and without the ignore bit, and with tick stopped. Stopping the tick separates the moment pending is raised from the wrap that clears it. A behavioural model is compared with the output and the read data on every cycle.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_LOCK   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned LOCK_BIT = 0;
  localparam int unsigned IGN_BIT  = 1;
  localparam int unsigned PEND_BIT = 8;

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int unsigned DUTY_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BC_W  = $clog2(DUTY_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_lock,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wrap,
  output logic [DUTY_W-1:0] act_duty,
  output logic [DUTY_W-1:0] act_per,
  output logic [BC_W-1:0]   act_bc,
  output logic              act_en,
  output logic              act_frac,
  output logic              apply,
  output logic              pending,
  output logic              eff_lock
);

  logic [DUTY_W-1:0] sh_duty_q, sh_duty_d, sh_per_q, sh_per_d;
  logic [BC_W-1:0]   sh_bc_q, sh_bc_d;
  logic              sh_en_q, sh_en_d, sh_frac_q, sh_frac_d;
  logic              lock_q, lock_d, ign_q, ign_d;
  logic              pend_q, pend_d, eff_q;
  logic [DUTY_W-1:0] a_duty_q, a_per_q;
  logic [BC_W-1:0]   a_bc_q;
  logic              a_en_q, a_frac_q;
  logic              wr_ctrl, wr_per, wr_lock, release_ev;

  always_comb begin
    wr_ctrl    = wr_en && (wr_addr == SEL_CTRL);
    wr_per     = wr_en && (wr_addr == SEL_PERIOD);
    wr_lock    = wr_en && (wr_addr == SEL_LOCK);
    eff_lock   = lock_q | (master_lock & ~ign_q);
    release_ev = eff_q & ~eff_lock;
    apply      = pend_q & ~eff_lock & wrap;

    sh_duty_d = sh_duty_q;
    sh_en_d   = sh_en_q;
    sh_frac_d = sh_frac_q;
    sh_per_d  = sh_per_q;
    sh_bc_d   = sh_bc_q;
    lock_d    = lock_q;
    ign_d     = ign_q;
    if (wr_ctrl) begin
      sh_duty_d = wr_data[DUTY_W-1:0];
      sh_en_d   = wr_data[DUTY_W];
      sh_frac_d = wr_data[DUTY_W+1];
    end
    if (wr_per) begin
      sh_per_d = wr_data[DUTY_W-1:0];
      sh_bc_d  = wr_data[DUTY_W +: BC_W];
    end
    if (wr_lock) begin
      lock_d = wr_data[LOCK_BIT];
      ign_d  = wr_data[IGN_BIT];
    end

    if (release_ev || ((wr_ctrl || wr_per) && !eff_lock)) pend_d = 1'b1;
    else if (apply)                                       pend_d = 1'b0;
    else                                                  pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_duty_q <= '0;
      sh_en_q   <= 1'b0;
      sh_frac_q <= 1'b0;
      sh_per_q  <= '0;
      sh_bc_q   <= '0;
      lock_q    <= 1'b0;
      ign_q     <= 1'b0;
      pend_q    <= 1'b0;
      eff_q     <= 1'b0;
    end else begin
      sh_duty_q <= sh_duty_d;
      sh_en_q   <= sh_en_d;
      sh_frac_q <= sh_frac_d;
      sh_per_q  <= sh_per_d;
      sh_bc_q   <= sh_bc_d;
      lock_q    <= lock_d;
      ign_q     <= ign_d;
      pend_q    <= pend_d;
      eff_q     <= eff_lock;
    end
  end

  // active copies load only on the apply enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_duty_q <= '0;
      a_per_q  <= '0;
      a_bc_q   <= '0;
      a_en_q   <= 1'b0;
      a_frac_q <= 1'b0;
    end else if (apply) begin
      a_duty_q <= sh_duty_q;
      a_per_q  <= sh_per_q;
      a_bc_q   <= sh_bc_q;
      a_en_q   <= sh_en_q;
      a_frac_q <= sh_frac_q;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      SEL_CTRL: begin
        rd_data[DUTY_W-1:0] = sh_duty_q;
        rd_data[DUTY_W]     = sh_en_q;
        rd_data[DUTY_W+1]   = sh_frac_q;
      end
      SEL_PERIOD: begin
        rd_data[DUTY_W-1:0]   = sh_per_q;
        rd_data[DUTY_W +: BC_W] = sh_bc_q;
      end
      SEL_LOCK: begin
        rd_data[LOCK_BIT] = lock_q;
        rd_data[IGN_BIT]  = ign_q;
        rd_data[PEND_BIT] = pend_q;
      end
      default: rd_data = '0;
    endcase
  end

  assign act_duty = a_duty_q;
  assign act_per  = a_per_q;
  assign act_bc   = a_bc_q;
  assign act_en   = a_en_q;
  assign act_frac = a_frac_q;
  assign pending  = pend_q;

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int unsigned DUTY_W = 16,
  localparam int unsigned BC_W  = $clog2(DUTY_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              apply,
  input  logic [DUTY_W-1:0] act_duty,
  input  logic [DUTY_W-1:0] act_per,
  input  logic [BC_W-1:0]   act_bc,
  input  logic              act_en,
  input  logic              act_frac,
  output logic              wrap,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] cnt,
  output logic [DUTY_W-1:0] per_eff
);

  localparam logic [BC_W:0] FULL = (BC_W+1)'(DUTY_W);

  logic [BC_W:0]     nbits, shamt;
  logic [DUTY_W-1:0] per_mask, lo_mask, frac_val, hi_int;
  logic [DUTY_W-1:0] cnt_q, cnt_d, acc_q, acc_d;
  logic              ext_q, ext_d, ovf;
  logic [DUTY_W:0]   sum, lim, hi_tot;

  always_comb begin
    nbits = (act_bc == '0) ? FULL : {1'b0, act_bc};
    shamt = FULL - nbits;
  end

  // period and fraction masks, one bit per position
  for (genvar i = 0; i < DUTY_W; i++) begin : g_mask
    assign per_mask[i] = ((BC_W+1)'(i) < nbits);
    assign lo_mask[i]  = ((BC_W+1)'(i) < shamt);
  end

  always_comb begin
    per_eff  = act_per & per_mask;
    hi_int   = act_duty >> shamt;
    frac_val = act_duty & lo_mask;
    lim      = {{DUTY_W{1'b0}}, 1'b1} << shamt;
    sum      = {1'b0, acc_q} + {1'b0, frac_val};
    ovf      = (sum >= lim);
    wrap     = tick && ((per_eff == '0) || (cnt_q >= per_eff - 1'b1));

    cnt_d = cnt_q;
    acc_d = acc_q;
    ext_d = ext_q;
    if (apply) begin
      cnt_d = '0;
      acc_d = '0;
      ext_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      if (act_frac) begin
        acc_d = ovf ? DUTY_W'(sum - lim) : sum[DUTY_W-1:0];
        ext_d = ovf;
      end else begin
        acc_d = '0;
        ext_d = 1'b0;
      end
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end

    hi_tot  = {1'b0, hi_int} + {{DUTY_W{1'b0}}, ext_q};
    pwm_out = act_en && (per_eff != '0) && ({1'b0, cnt_q} < hi_tot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      ext_q <= ext_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
  parameter int unsigned DUTY_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              master_lock,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out
);

  localparam int unsigned BC_W = $clog2(DUTY_W);

  logic [DUTY_W-1:0] act_duty, act_per, cnt, per_eff;
  logic [BC_W-1:0]   act_bc;
  logic              act_en, act_frac, apply, pending, eff_lock, wrap;

  bl_pwm_regs #(.DUTY_W(DUTY_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_lock(master_lock),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .wrap       (wrap),
    .act_duty   (act_duty),
    .act_per    (act_per),
    .act_bc     (act_bc),
    .act_en     (act_en),
    .act_frac   (act_frac),
    .apply      (apply),
    .pending    (pending),
    .eff_lock   (eff_lock)
  );

  bl_pwm_core #(.DUTY_W(DUTY_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .apply   (apply),
    .act_duty(act_duty),
    .act_per (act_per),
    .act_bc  (act_bc),
    .act_en  (act_en),
    .act_frac(act_frac),
    .wrap    (wrap),
    .pwm_out (pwm_out),
    .cnt     (cnt),
    .per_eff (per_eff)
  );

endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int unsigned DUTY_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              eff_lock,
  input logic              pending,
  input logic              apply,
  input logic [DUTY_W-1:0] cnt,
  input logic [DUTY_W-1:0] per_eff
);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_eff != '0) |-> (cnt < per_eff));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R6
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_lock && pending) |=> pending);

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> ($past(apply) && cnt == '0));

  // R7
  apply_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (cnt == '0));

endmodule

bind bl_pwm_gen bl_pwm_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .eff_lock(eff_lock),
  .pending (pending),
  .apply   (apply),
  .cnt     (cnt),
  .per_eff (per_eff)
);

// File: tb/test_bl_pwm_gen.sv
module test_bl_pwm_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        master_lock = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int total = 0, bad = 0;
  int tick_div = 0, tcnt = 0;
  string cur_req = "R1";

  // model state
  int m_duty, m_en, m_frac, m_per, m_bc, m_lock, m_ign, m_pend, m_effq;
  int a_duty, a_en, a_frac, a_per, a_bc, m_cnt, m_acc, m_ext;

  bl_pwm_gen i_bl_pwm_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .master_lock(master_lock),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  function automatic int nb_of(int bc);
    return (bc == 0) ? 16 : bc;
  endfunction

  function automatic int peff(int per, int bc);
    return per & ((1 << nb_of(bc)) - 1);
  endfunction

  function automatic int model_pwm();
    int pe, hi;
    pe = peff(a_per, a_bc);
    hi = (a_duty >> (16 - nb_of(a_bc))) + m_ext;
    return (a_en != 0 && pe != 0 && m_cnt < hi) ? 1 : 0;
  endfunction

  function automatic int model_rd(int a);
    case (a)
      0: return m_duty | (m_en << 16) | (m_frac << 17);
      1: return m_per | (m_bc << 16);
      2: return m_lock | (m_ign << 1) | (m_pend << 8);
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_duty = 0; m_en = 0; m_frac = 0; m_per = 0; m_bc = 0;
    m_lock = 0; m_ign = 0; m_pend = 0; m_effq = 0;
    a_duty = 0; a_en = 0; a_frac = 0; a_per = 0; a_bc = 0;
    m_cnt = 0; m_acc = 0; m_ext = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int eff, rel, wrp, app, pe, wd, f, s;
      pe  = peff(a_per, a_bc);
      wrp = (tick && (pe == 0 || m_cnt >= pe - 1)) ? 1 : 0;
      eff = (m_lock != 0 || (master_lock && m_ign == 0)) ? 1 : 0;
      rel = (m_effq != 0 && eff == 0) ? 1 : 0;
      app = (m_pend != 0 && eff == 0 && wrp != 0) ? 1 : 0;
      wd  = (wr_en && wr_addr < 2) ? 1 : 0;
      if (app != 0) begin
        a_duty = m_duty; a_en = m_en; a_frac = m_frac; a_per = m_per; a_bc = m_bc;
        m_cnt = 0; m_acc = 0; m_ext = 0;
      end else if (wrp != 0) begin
        m_cnt = 0;
        if (a_frac != 0) begin
          f = 16 - nb_of(a_bc);
          s = m_acc + (a_duty & ((1 << f) - 1));
          if (s >= (1 << f)) begin s = s - (1 << f); m_ext = 1; end
          else m_ext = 0;
          m_acc = s;
        end else begin m_acc = 0; m_ext = 0; end
      end else if (tick) m_cnt++;
      if (rel != 0 || (wd != 0 && eff == 0)) m_pend = 1;
      else if (app != 0) m_pend = 0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_duty = int'(wr_data[15:0]); m_en = int'(wr_data[16]); m_frac = int'(wr_data[17]); end
          2'd1: begin m_per = int'(wr_data[15:0]); m_bc = int'(wr_data[19:16]); end
          2'd2: begin m_lock = int'(wr_data[0]); m_ign = int'(wr_data[1]); end
          default: ;
        endcase
      end
      m_effq = eff;
    end
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (int'(pwm_out) != model_pwm()) begin
        bad++;
        $display("FAIL %s pwm_out got %0d exp %0d at %0t", cur_req, pwm_out, model_pwm(), $time);
      end
      total++;
      if (int'(rd_data) != model_rd(int'(rd_addr))) begin
        bad++;
        $display("FAIL %s rd_data got %h exp %h at %0t", cur_req, rd_data, model_rd(int'(rd_addr)), $time);
      end
    end
  end

  always @(posedge clk) begin
    #2;
    tcnt++;
    tick = (tick_div != 0) && ((tcnt % tick_div) == 0);
  end

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 32'(d);
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rdchk(string req, int a, int exp);
    @(posedge clk); #2;
    rd_addr = 2'(a);
    @(negedge clk);
    chk(req, int'(rd_data), exp);
  endtask

  task automatic highs(string req, int n, int exp);
    int c = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
    chk(req, c, exp);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run(4); #2; rst_n = 1'b1;
    cur_req = "R1";
    rdchk("R1 ctrl", 0, 0);
    rdchk("R1 period", 1, 0);
    rdchk("R1 lock", 2, 0);
    rdchk("R1 unused", 3, 0);
    chk("R1 pwm", int'(pwm_out), 0);

    cur_req = "R9";
    wr(1, (4 << 16) | 16'h00FA);
    rdchk("R9 pending after unlocked write", 2, 32'h100);
    wr(0, (1 << 16) | 16'h3000);
    tick_div = 1;
    run(30);
    rdchk("R9 pending cleared", 2, 0);

    cur_req = "R3";
    highs("R3 masked period 10 duty 3", 20, 6);

    cur_req = "R2";
    wr(1, 20);
    wr(0, (1 << 16) | 16'h0007);
    run(60);
    highs("R2 bitcount 0 means 16", 40, 14);
    wr(1, (4 << 16) | 16'h00FA);
    wr(0, (1 << 16) | 16'h3000);
    tick_div = 3;
    run(80);
    highs("R2 slow tick", 60, 18);

    cur_req = "R4";
    tick_div = 1;
    wr(1, (4 << 16) | 8);
    wr(0, (3 << 16) | 16'h3800);
    run(40);
    highs("R4 fractional half", 80, 35);
    cur_req = "R3";
    wr(0, (1 << 16) | 16'h3800);
    run(40);
    highs("R3 low duty bits ignored", 80, 30);

    cur_req = "R5";
    wr(0, 16'h3800);
    run(30);
    highs("R5 disabled", 40, 0);
    wr(0, (1 << 16) | 16'h3800);
    wr(1, (4 << 16) | 16'h0100);
    run(30);
    highs("R5 zero period", 40, 0);

    cur_req = "R6";
    wr(1, (4 << 16) | 10);
    wr(0, (1 << 16) | 16'h3000);
    run(30);
    wr(2, 1);
    wr(0, (1 << 16) | 16'h6000);
    run(40);
    highs("R6 locked keeps old duty", 20, 6);
    rdchk("R6 no pending while locked", 2, 1);

    cur_req = "R7";
    tick_div = 0;
    wr(2, 0);
    run(2);
    rdchk("R7 pending after release", 2, 32'h100);
    tick_div = 1;
    run(20);
    rdchk("R7 pending cleared at wrap", 2, 0);
    highs("R7 new duty applied", 20, 12);

    cur_req = "R8";
    master_lock = 1'b1;
    wr(0, (1 << 16) | 16'h2000);
    run(30);
    highs("R8 master lock holds", 20, 12);
    rdchk("R8 no pending under master", 2, 0);
    wr(2, 2);
    run(30);
    highs("R8 ignore bit releases", 20, 4);
    rdchk("R8 lock readback", 2, 2);
    master_lock = 1'b0;

    cur_req = "R10";
    wr(0, 32'h0003_ABCD);
    rdchk("R10 ctrl readback", 0, 32'h0003_ABCD);
    wr(1, 32'h000F_1234);
    rdchk("R10 period readback", 1, 32'h000F_1234);
    rdchk("R10 unused address", 3, 0);
    run(10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule